// File: doc/BRIEF.md
# Trimmed Counter with Match Interrupts

This block is a free-running counter that advances at a slow base rate of 32768 Hz. The slow domain is represented by a single-cycle tick-enable pulse in the main clock domain. The tick can pass through a 16-bit trim prescaler, or the prescaler can be bypassed. The counter value is compared against three match values. Each match raises its own sticky interrupt flag when the counter takes on that value.

Software uses a plain word-wide register port to program the run/bypass controls, the trim value, a counter load value and the three match values. Every writable register is staged: a write parks the value in a shadow copy and raises a pending-write bit. The value moves into effect on the next slow tick, and the pending bit then clears. A write to a register whose pending bit is still set is dropped. No data streams through the block, so every pin is a plain control or status pin with no handshake.

The register map uses these addresses: 0 control (bit 0 run, bit 1 bypass), 1 trim, 2 load, 3 to 5 match 0 to 2, 6 pending status, 7 live count and 8 interrupt flags.

Top module: `trim_match_counter`

## Requirements
- R1: After reset, the count, control, trim, load and match values are zero, every pending bit is clear and `irq` is zero.
- R2: Writing address 0, 1, 2, 3, 4 or 5 sets status bit 0, 1, 2, 3, 4 or 5 respectively. The value read back from that address keeps its old value until the next `slow_tick`. On that tick the new value takes effect and the status bit clears.
- R3: A write to a register whose pending bit is set has no effect on the value that is later applied.
- R4: With the run bit (control bit 0) clear, ticks leave the count unchanged.
- R5: With run and bypass (control bit 1) set, the count rises by one on every tick.
- R6: With run set and bypass clear, a trim value of N advances the count once every N+1 ticks.
- R7: On the tick that applies a pending load, the count takes the load value instead of advancing, and the prescaler restarts. Applying a new trim value also restarts the prescaler.
- R8: The count wraps from all ones to zero.
- R9: When a tick updates the count to a value equal to match k, `irq[k]` is set. The flag stays set while it is not cleared.
- R10: Writing address 8 clears every flag whose data bit is 1. A flag set in the same cycle as its clear stays set.
- R11: Reading address 7 returns the current count, and reading address 6 returns the pending bits in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse at the 32768 Hz base rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CNT_W | Combinational read data |
| irq | output | NUM_MATCH | Sticky match interrupt flags |

## Verification
The bench builds the block with its defaults: a 32-bit count, a 16-bit trim and three match units. The wrap from all ones is reached quickly by loading a value just below it rather than by counting up. Random trims are kept at 0 to 3, so several full prescaler periods fit into a short run. Random match values are placed a few steps ahead of the live count, so matches, set-versus-clear collisions and dropped writes to pending registers all occur often.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  // pending-bit positions, also the write addresses of the staged registers
  localparam int PB_CTRL   = 0;
  localparam int PB_TRIM   = 1;
  localparam int PB_LOAD   = 2;
  localparam int PB_MATCH0 = 3;

  typedef struct packed {
    logic bypass;  // bit 1
    logic run;     // bit 0
  } ctrl_t;
endpackage

// File: rtl/tmc_stage_reg.sv
module tmc_stage_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] d,
  output logic [W-1:0] shadow,
  output logic [W-1:0] act,
  output logic         pend,
  output logic         apply
);
  assign apply = tick & pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      act    <= '0;
      pend   <= 1'b0;
    end else if (wr && !pend) begin
      shadow <= d;
      pend   <= 1'b1;
    end else if (tick && pend) begin
      act  <= shadow;
      pend <= 1'b0;
    end
  end

  // R3
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && pend) |=> $stable(shadow));

  // R2
  tick_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend) |=> (!pend && act == $past(shadow)));
endmodule

// File: rtl/tmc_count_core.sv
module tmc_count_core #(
  parameter int CNT_W  = 32,
  parameter int TRIM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              bypass,
  input  logic [TRIM_W-1:0] trim,
  input  logic              trim_go,
  input  logic              load_go,
  input  logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  count,
  output logic              upd,
  output logic [CNT_W-1:0]  next_count
);
  logic [TRIM_W-1:0] presc;
  logic              wrap_pt;
  logic              adv;

  assign wrap_pt    = (presc == trim);
  assign adv        = tick & run & (bypass | wrap_pt);
  assign upd        = load_go | adv;
  assign next_count = load_go ? load_val : count + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
    end else if (tick) begin
      if (load_go || trim_go || !run || bypass || wrap_pt) presc <= '0;
      else presc <= presc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (upd) count <= next_count;
  end

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !run && !load_go) |=> $stable(count));

  // R5
  bypass_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && bypass && !load_go) |=> (count == $past(count) + 1'b1));

  // R7
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> (count == $past(load_val)));

  // R6
  presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    presc <= trim);
endmodule

// File: rtl/tmc_match_flag.sv
module tmc_match_flag #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [CNT_W-1:0] next_count,
  input  logic [CNT_W-1:0] match_val,
  input  logic             clr,
  output logic             flag
);
  logic hit;
  assign hit = upd & (next_count == match_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else flag <= (flag & ~clr) | hit;
  end

  // R9
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  // R9
  rise_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(upd));
endmodule

// File: rtl/trim_match_counter.sv
module trim_match_counter
  import tmc_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int TRIM_W    = 16,
  parameter int NUM_MATCH = 3,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slow_tick,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [CNT_W-1:0]     rd_data,
  output logic [NUM_MATCH-1:0] irq
);
  localparam int NPEND      = PB_MATCH0 + NUM_MATCH;
  localparam int ADR_STATUS = NPEND;
  localparam int ADR_COUNT  = NPEND + 1;
  localparam int ADR_IRQ    = NPEND + 2;

  logic [NPEND-1:0] pend;
  logic [NPEND-1:0] apply;
  logic [NPEND-1:0] wr_sel;

  ctrl_t             ctrl_act, ctrl_sh;
  logic [TRIM_W-1:0] trim_act, trim_sh;
  logic [CNT_W-1:0]  load_act, load_sh;
  logic [CNT_W-1:0]  match_act [NUM_MATCH];
  logic [CNT_W-1:0]  count, next_count;
  logic              upd;
  logic [NUM_MATCH-1:0] clr;

  always_comb begin
    for (int i = 0; i < NPEND; i++)
      wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
  end

  assign clr = (wr_en && wr_addr == ADDR_W'(ADR_IRQ)) ? wr_data[NUM_MATCH-1:0] : '0;

  tmc_stage_reg #(.W(2)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .wr(wr_sel[PB_CTRL]),
    .d(wr_data[1:0]), .shadow(ctrl_sh), .act(ctrl_act),
    .pend(pend[PB_CTRL]), .apply(apply[PB_CTRL]));

  tmc_stage_reg #(.W(TRIM_W)) u_trim (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .wr(wr_sel[PB_TRIM]),
    .d(wr_data[TRIM_W-1:0]), .shadow(trim_sh), .act(trim_act),
    .pend(pend[PB_TRIM]), .apply(apply[PB_TRIM]));

  tmc_stage_reg #(.W(CNT_W)) u_load (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .wr(wr_sel[PB_LOAD]),
    .d(wr_data), .shadow(load_sh), .act(load_act),
    .pend(pend[PB_LOAD]), .apply(apply[PB_LOAD]));

  tmc_count_core #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick),
    .run(ctrl_act.run), .bypass(ctrl_act.bypass), .trim(trim_act),
    .trim_go(apply[PB_TRIM]), .load_go(apply[PB_LOAD]), .load_val(load_sh),
    .count(count), .upd(upd), .next_count(next_count));

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_match
    logic [CNT_W-1:0] m_sh;
    tmc_stage_reg #(.W(CNT_W)) u_mreg (
      .clk(clk), .rst_n(rst_n), .tick(slow_tick), .wr(wr_sel[PB_MATCH0+k]),
      .d(wr_data), .shadow(m_sh), .act(match_act[k]),
      .pend(pend[PB_MATCH0+k]), .apply(apply[PB_MATCH0+k]));

    tmc_match_flag #(.CNT_W(CNT_W)) u_flag (
      .clk(clk), .rst_n(rst_n), .upd(upd), .next_count(next_count),
      .match_val(match_act[k]), .clr(clr[k]), .flag(irq[k]));
  end

  logic unused_sh;
  assign unused_sh = ^{ctrl_sh, trim_sh};

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(PB_CTRL))         rd_data = CNT_W'(ctrl_act);
    else if (rd_addr == ADDR_W'(PB_TRIM))    rd_data = CNT_W'(trim_act);
    else if (rd_addr == ADDR_W'(PB_LOAD))    rd_data = load_act;
    else if (rd_addr == ADDR_W'(ADR_STATUS)) rd_data = CNT_W'(pend);
    else if (rd_addr == ADDR_W'(ADR_COUNT))  rd_data = count;
    else if (rd_addr == ADDR_W'(ADR_IRQ))    rd_data = CNT_W'(irq);
    else begin
      for (int k = 0; k < NUM_MATCH; k++)
        if (rd_addr == ADDR_W'(PB_MATCH0 + k)) rd_data = match_act[k];
    end
  end

  // R8
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !apply[PB_LOAD] && count == '1) |=> (count == '0));

  // R11
  pend_onehot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend & ~$past(pend)));
endmodule

// File: tb/trim_match_counter_test.sv
module trim_match_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [2:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  trim_match_counter uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq));

  // ---------------- reference model from the requirements ----------------
  logic [31:0] m_sh  [6];
  logic [31:0] m_act [6];
  logic [5:0]  m_pend;
  logic [31:0] m_cnt, m_nc;
  logic [15:0] m_presc;
  logic [2:0]  m_irq, m_set, m_clr;
  logic        m_upd;

  function automatic logic [31:0] wmask(input int i);
    if (i == 0) return 32'h3;
    if (i == 1) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin m_sh[i] = '0; m_act[i] = '0; end
      m_pend = '0; m_cnt = '0; m_presc = '0; m_irq = '0;
    end else begin
      m_upd = 1'b0; m_nc = m_cnt;
      if (slow_tick) begin
        if (m_pend[2]) begin m_nc = m_sh[2]; m_upd = 1'b1; end
        else if (m_act[0][0] && (m_act[0][1] || m_presc == m_act[1][15:0])) begin
          m_nc = m_cnt + 1; m_upd = 1'b1;
        end
        if (m_pend[2] || m_pend[1] || !m_act[0][0] || m_act[0][1] ||
            m_presc == m_act[1][15:0]) m_presc = '0;
        else m_presc = m_presc + 1;
      end
      m_set = '0;
      for (int k = 0; k < 3; k++) if (m_upd && m_nc == m_act[3+k]) m_set[k] = 1'b1;
      m_clr = (wr_en && wr_addr == 4'd8) ? wr_data[2:0] : 3'b0;
      m_irq = (m_irq & ~m_clr) | m_set;
      m_cnt = m_nc;
      for (int i = 0; i < 6; i++) begin
        if (wr_en && wr_addr == 4'(i) && !m_pend[i]) begin
          m_sh[i] = wr_data & wmask(i); m_pend[i] = 1'b1;
        end else if (slow_tick && m_pend[i]) begin
          m_act[i] = m_sh[i]; m_pend[i] = 1'b0;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic cyc(input logic t, input logic w, input logic [3:0] a, input logic [31:0] d);
    slow_tick = t; wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    slow_tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 4'd0, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] seed;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc(0, 0, 0, 0);

    // R1 reset state
    rd(4'd7, v); chk("R1 count", v, 0);
    rd(4'd6, v); chk("R1 status", v, 0);
    rd(4'd0, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", {29'd0, irq}, 0);

    // R2 staged trim write
    cyc(0, 1, 4'd1, 32'd2);
    rd(4'd6, v); chk("R2 trim pending", v, 32'h2);
    rd(4'd1, v); chk("R2 trim old value", v, 0);
    // R3 write while pending dropped
    cyc(0, 1, 4'd1, 32'd5);
    tk(1);
    rd(4'd6, v); chk("R2 status cleared", v, 0);
    rd(4'd1, v); chk("R3 trim kept first", v, 2);

    // R4 halted
    tk(3);
    rd(4'd7, v); chk("R4 halted", v, 0);

    // R6 trim 2 -> every 3 ticks
    cyc(0, 1, 4'd0, 32'd1);
    rd(4'd6, v); chk("R2 ctrl pending", v, 32'h1);
    tk(1);
    tk(2);
    rd(4'd7, v); chk("R6 before period", v, 0);
    tk(1);
    rd(4'd7, v); chk("R6 one period", v, 1);

    // R5 bypass
    cyc(0, 1, 4'd0, 32'd3);
    tk(1);
    tk(4);
    rd(4'd7, v); chk("R5 bypass", v, 5);

    // R7 load, R8 wrap
    cyc(0, 1, 4'd2, 32'hFFFF_FFFE);
    tk(1);
    rd(4'd7, v); chk("R7 load", v, 32'hFFFF_FFFE);
    tk(1);
    rd(4'd7, v); chk("R8 all ones", v, 32'hFFFF_FFFF);
    tk(1);
    rd(4'd7, v); chk("R8 wrap", v, 0);
    chk("R9 zero matches", {29'd0, irq}, 32'h7);
    cyc(0, 1, 4'd8, 32'h7);
    chk("R10 clear all", {29'd0, irq}, 0);

    // R9 match 0 at 3
    cyc(0, 1, 4'd3, 32'd3);
    tk(1);
    tk(1);
    chk("R9 no early hit", {29'd0, irq}, 0);
    tk(1);
    chk("R9 hit", {29'd0, irq}, 32'h1);
    tk(1);
    chk("R9 sticky", {29'd0, irq}, 32'h1);
    cyc(0, 1, 4'd8, 32'h1);
    chk("R10 w1c", {29'd0, irq}, 0);

    // R10 set wins over clear
    cyc(0, 1, 4'd4, 32'd6);
    tk(1);
    cyc(1, 1, 4'd8, 32'h2);
    chk("R10 set wins", {29'd0, irq}, 32'h2);
    rd(4'd7, v); chk("R11 count read", v, 6);
    cyc(0, 1, 4'd8, 32'h2);

    // random mix against the model
    for (int n = 0; n < 3000; n++) begin
      logic        t, w;
      logic [3:0]  a;
      logic [31:0] d;
      t = ($urandom % 3) == 0;
      w = $urandom % 2;
      a = 4'($urandom % 9);
      case (a)
        4'd0:    d = $urandom % 4;
        4'd1:    d = $urandom % 4;
        4'd2:    d = (($urandom % 4) == 0) ? 32'hFFFF_FFF0 + ($urandom % 16) : $urandom % 64;
        4'd8:    d = $urandom % 8;
        default: d = m_cnt + ($urandom % 8);
      endcase
      cyc(t, w, a, d);
      rd(4'd7, v); chk("R11 random count", v, m_cnt);
      rd(4'd6, v); chk("R2 random status", v, {26'd0, m_pend});
      rd(4'd0, v); chk("R3 random ctrl", v, m_act[0]);
      chk("R9 random irq", {29'd0, irq}, {29'd0, m_irq});
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule